// File: doc/BRIEF.md
# Zero-Run Byte Stream Compressor

This block compresses a byte stream by replacing each run of zero bytes with a two-byte token: a 0x00 marker followed by the length of the run. Every nonzero byte passes through unchanged. No escape byte is used, so every zero in the output is a marker, and the byte after it is always a count. A count of zero never describes a run. It is reserved for the end of the stream.

Bytes arrive on a valid/ready input with a `last` flag on the final byte of a stream, and compressed bytes leave on a valid/ready output. When the last byte has been taken, the block closes any open run and then appends two tokens. The first is a padding token for four zero bytes. The second is the end-of-data pair. A small output queue absorbs the worst-case burst that one input byte can cause. Input is stalled whenever that burst would not fit, so back-pressure on the output never loses a byte.

Top module: `zrun_compressor`

## Requirements
- R1: A nonzero input byte appears on the output once, unchanged, in stream order.
- R2: A run of N consecutive zero bytes, with 1 <= N <= 255, ending before a nonzero byte is emitted as 0x00 then N. A lone zero gives 0x00, 0x01.
- R3: A zero run longer than 255 is emitted as as many 0x00, 0xFF tokens as it holds full blocks of 255 zeros, followed by one 0x00, remainder token when the remainder is not zero.
- R4: A zero run still open when the byte flagged `last` is accepted is emitted as its own 0x00, count token, ahead of the padding token.
- R5: After each stream the block emits 0x00, 0x04 and then 0x00, 0x00. In the cycle after a `last` byte is accepted, `in_ready` is low.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays unchanged in the next cycle.
- R7: `in_ready` is high only when the output queue holds at most one byte, so that the queue never overflows.
- R8: With `rst_n` low at a clock edge, the block clears its run counter and any queued bytes. After reset `out_valid` is low and `in_ready` is high, and no zeros received before the reset are counted afterwards.
- R9: A new stream may start as soon as `in_ready` returns after the end marker. It carries no run state from the previous stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input byte is offered |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Offered byte is the last byte of the stream |
| in_ready | output | 1 | Block accepts the offered byte this cycle |
| out_valid | output | 1 | Output byte is available |
| out_data | output | 8 | Output byte |
| out_ready | input | 1 | Downstream takes the output byte this cycle |

## Verification
The bench targets the run-length boundaries: a lone zero, a run of exactly 255, one of 256, and a long run of 600. A counter that wraps or splits one byte too late would emit a zero count, or a count one off, in the middle of the data. Streams that end on a zero run check that the open run is flushed before the padding token, and not dropped or merged into the trailer. Random output stalls check that a byte held under back-pressure does not change and that a three-byte burst is not lost. A reset in the middle of a run checks that the stale count does not leak into the next stream.

// File: rtl/zrun_pkg.sv
// Shared constants and types for the zero-run compressor.
// Assumes byte-wide data. At most three bytes are produced per step.
package zrun_pkg;
    localparam int BYTE_W   = 8;
    localparam int MAX_PUSH = 3;
    localparam int PUSH_W   = 2;

    typedef logic [BYTE_W-1:0] byte_t;

    // Sequencer phase: taking data, closing a run, padding token, end marker
    typedef enum logic [1:0] {
        PH_DATA  = 2'd0,
        PH_FLUSH = 2'd1,
        PH_PAD   = 2'd2,
        PH_END   = 2'd3
    } phase_e;
endpackage

// File: rtl/zrun_outq.sv
// Small circular output queue. It takes up to MAX_PUSH bytes per cycle
// and pops one byte per accepted handshake.
// Assumes DEPTH is a power of two and that the producer never pushes
// more bytes than the reported free space.
module zrun_outq
    import zrun_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic [PUSH_W-1:0]                     push_n,
    input  logic [MAX_PUSH-1:0][BYTE_W-1:0]       push_b,
    output logic                                  out_valid,
    input  logic                                  out_ready,
    output byte_t                                 out_data,
    output logic [$clog2(DEPTH):0]                level,
    output logic [$clog2(DEPTH):0]                free
);
    localparam int AW    = $clog2(DEPTH);
    localparam int LVL_W = AW + 1;

    byte_t              mem [DEPTH];
    logic [AW-1:0]      rd_ptr;
    logic [LVL_W-1:0]   count;
    logic               pop;

    // Pop on every handshake while data is present
    always_comb pop = (count != '0) && out_ready;

    // Pointer and occupancy update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (pop) rd_ptr <= rd_ptr + AW'(1);
            count <= count + LVL_W'(push_n) - LVL_W'(pop);
        end
    end

    // Write the pushed bytes into consecutive slots after the tail
    always_ff @(posedge clk) begin
        for (int i = 0; i < MAX_PUSH; i++) begin
            if (rst_n && (int'(push_n) > i))
                mem[rd_ptr + count[AW-1:0] + AW'(i)] <= push_b[i];
        end
    end

    // Head of queue drives the output port
    always_comb begin
        out_valid = (count != '0);
        out_data  = mem[rd_ptr];
        level     = count;
        free      = LVL_W'(DEPTH) - count;
    end
endmodule

// File: rtl/zrun_encoder.sv
// Run counter and stream sequencer. It turns each accepted byte into
// 0 to 3 output bytes, then after the last byte emits the run flush,
// the padding token and the end marker, one step per phase.
// Assumes q_free is the queue's current free space. Input is taken only
// when the worst case of three bytes fits.
module zrun_encoder
    import zrun_pkg::*;
#(
    parameter int MAX_RUN = 255,
    parameter int PAD_LEN = 4,
    parameter int LVL_W   = 3
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              in_valid,
    input  byte_t                             in_data,
    input  logic                              in_last,
    output logic                              in_ready,
    input  logic [LVL_W-1:0]                  q_free,
    output logic [PUSH_W-1:0]                 push_n,
    output logic [MAX_PUSH-1:0][BYTE_W-1:0]   push_b
);
    localparam byte_t RUN_CAP  = BYTE_W'(MAX_RUN);
    localparam byte_t PAD_CODE = BYTE_W'(PAD_LEN);

    phase_e phase_q, phase_d;
    byte_t  cnt_q, cnt_d;
    logic   room_pair, room_all, take;

    // Next-state, push selection and input readiness
    always_comb begin
        phase_d   = phase_q;
        cnt_d     = cnt_q;
        push_n    = '0;
        push_b    = '0;
        room_pair = (q_free >= LVL_W'(2));
        room_all  = (q_free >= LVL_W'(MAX_PUSH));
        in_ready  = (phase_q == PH_DATA) && room_all;
        take      = in_valid && in_ready;
        case (phase_q)
            PH_DATA: begin
                if (take) begin
                    if (in_data == '0) begin
                        if (cnt_q == RUN_CAP) begin
                            push_n    = PUSH_W'(2);
                            push_b[1] = RUN_CAP;
                            cnt_d     = BYTE_W'(1);
                        end else begin
                            cnt_d = cnt_q + BYTE_W'(1);
                        end
                    end else if (cnt_q != '0) begin
                        push_n    = PUSH_W'(3);
                        push_b[1] = cnt_q;
                        push_b[2] = in_data;
                        cnt_d     = '0;
                    end else begin
                        push_n    = PUSH_W'(1);
                        push_b[0] = in_data;
                    end
                    if (in_last) phase_d = PH_FLUSH;
                end
            end
            PH_FLUSH: begin
                if (room_pair) begin
                    if (cnt_q != '0) begin
                        push_n    = PUSH_W'(2);
                        push_b[1] = cnt_q;
                    end
                    cnt_d   = '0;
                    phase_d = PH_PAD;
                end
            end
            PH_PAD: begin
                if (room_pair) begin
                    push_n    = PUSH_W'(2);
                    push_b[1] = PAD_CODE;
                    phase_d   = PH_END;
                end
            end
            default: begin
                if (room_pair) begin
                    push_n  = PUSH_W'(2);
                    phase_d = PH_DATA;
                end
            end
        endcase
    end

    // State registers with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_DATA;
            cnt_q   <= '0;
        end else begin
            phase_q <= phase_d;
            cnt_q   <= cnt_d;
        end
    end
endmodule

// File: rtl/zrun_compressor.sv
// Top level of the zero-run compressor. It connects the run encoder to
// the output queue.
// Assumes QDEPTH >= MAX_PUSH + 1, QDEPTH a power of two, and
// MAX_RUN and PAD_LEN both within 1..255.
module zrun_compressor #(
    parameter int MAX_RUN = 255,
    parameter int PAD_LEN = 4,
    parameter int QDEPTH  = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    input  logic       in_last,
    output logic       in_ready,
    output logic       out_valid,
    output logic [7:0] out_data,
    input  logic       out_ready
);
    import zrun_pkg::*;

    localparam int LVL_W = $clog2(QDEPTH) + 1;

    logic [PUSH_W-1:0]               push_n;
    logic [MAX_PUSH-1:0][BYTE_W-1:0] push_b;
    logic [LVL_W-1:0]                q_level;
    logic [LVL_W-1:0]                q_free;

    zrun_encoder #(
        .MAX_RUN (MAX_RUN),
        .PAD_LEN (PAD_LEN),
        .LVL_W   (LVL_W)
    ) u_enc (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_data  (in_data),
        .in_last  (in_last),
        .in_ready (in_ready),
        .q_free   (q_free),
        .push_n   (push_n),
        .push_b   (push_b)
    );

    zrun_outq #(
        .DEPTH (QDEPTH)
    ) u_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_n    (push_n),
        .push_b    (push_b),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data),
        .level     (q_level),
        .free      (q_free)
    );
endmodule

// File: rtl/zrun_compressor_chk.sv
// Property checker for the zero-run compressor, bound to the top.
// Assumes it sees the top's ports and its queue occupancy.
module zrun_compressor_chk #(
    parameter int QDEPTH = 4,
    parameter int LVL_W  = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             in_last,
    input logic             out_valid,
    input logic             out_ready,
    input logic [7:0]       out_data,
    input logic [LVL_W-1:0] q_level
);
    // R6: a stalled byte stays offered
    assert_hold_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> out_valid);

    // R6: a stalled byte keeps its value
    assert_hold_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> $stable(out_data));

    // R7: input is offered only when the worst-case burst fits
    assert_ready_room_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (q_level <= LVL_W'(QDEPTH - 3)));

    // R7: queue occupancy never exceeds its depth
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        q_level <= LVL_W'(QDEPTH));

    // R5: trailer phases block input right after the last byte
    assert_last_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_last) |=> !in_ready);
endmodule

bind zrun_compressor zrun_compressor_chk #(
    .QDEPTH (QDEPTH),
    .LVL_W  (LVL_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_last   (in_last),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .q_level   (q_level)
);

// File: tb/zrun_compressor_tb.sv
// Scoreboard bench. The driver computes the expected compressed bytes from
// the requirements and queues them. The monitor compares each output
// handshake with the queue and checks that stalled bytes are held.
module zrun_compressor_tb;
    typedef struct {
        logic [7:0] v;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_last = 1'b0;
    logic       in_ready;
    logic       out_valid;
    logic [7:0] out_data;
    logic       out_ready = 1'b1;

    int   n_checks = 0;
    int   n_fail   = 0;
    bit   bp_on    = 1'b0;
    exp_t exp_q[$];

    always #4 clk = ~clk;

    zrun_compressor u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_last   (in_last),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_ready (out_ready)
    );

    // Record one check result and report a failure
    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    task automatic expect_byte(input logic [7:0] v, input string tag);
        exp_t e;
        e.v = v;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Expected output of one stream, derived from R1..R5
    task automatic model_stream(input logic [7:0] s[$]);
        int cnt = 0;
        foreach (s[i]) begin
            if (s[i] == 8'h00) begin
                if (cnt == 255) begin
                    expect_byte(8'h00, "R3");
                    expect_byte(8'hFF, "R3");
                    cnt = 1;
                end else begin
                    cnt++;
                end
            end else begin
                if (cnt != 0) begin
                    expect_byte(8'h00, "R2");
                    expect_byte(8'(cnt), "R2");
                end
                expect_byte(s[i], "R1");
                cnt = 0;
            end
        end
        if (cnt != 0) begin
            expect_byte(8'h00, "R4");
            expect_byte(8'(cnt), "R4");
        end
        expect_byte(8'h00, "R5");
        expect_byte(8'h04, "R5");
        expect_byte(8'h00, "R5");
        expect_byte(8'h00, "R5");
    endtask

    // Offer one byte from a negedge and return at the negedge after acceptance
    task automatic send_byte(input logic [7:0] b, input bit l);
        in_valid = 1'b1;
        in_data  = b;
        in_last  = l;
        forever begin
            #3;
            if (in_ready) break;
            @(negedge clk);
        end
        @(negedge clk);
    endtask

    // Queue the expected output and drive a full stream
    task automatic run_stream(input logic [7:0] s[$]);
        model_stream(s);
        foreach (s[i]) send_byte(s[i], i == s.size() - 1);
        in_valid = 1'b0;
        in_last  = 1'b0;
        #3;
        check(!in_ready, "R5", "in_ready after last", int'(in_ready), 0);
        @(negedge clk);
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    // Output back-pressure driver
    initial forever begin
        @(negedge clk);
        out_ready = bp_on ? ($urandom % 3 != 0) : 1'b1;
    end

    // Monitor: compare each handshake and check hold behaviour
    initial begin
        bit         hold_pend = 1'b0;
        logic [7:0] hold_data = '0;
        exp_t       e;
        forever begin
            @(negedge clk);
            #3;
            if (!rst_n) begin
                hold_pend = 1'b0;
            end else begin
                if (hold_pend) begin
                    check(out_valid, "R6", "valid held", int'(out_valid), 1);
                    check(out_data == hold_data, "R6", "data held", int'(out_data), int'(hold_data));
                end
                hold_pend = out_valid && !out_ready;
                hold_data = out_data;
                if (out_valid && out_ready) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R1", "unexpected output byte", int'(out_data), -1);
                    end else begin
                        e = exp_q.pop_front();
                        check(out_data == e.v, e.tag, "output byte", int'(out_data), int'(e.v));
                    end
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    // Test sequence
    initial begin
        logic [7:0] s[$];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #3;
        check(!out_valid, "R8", "out_valid after reset", int'(out_valid), 0);
        check(in_ready, "R8", "in_ready after reset", int'(in_ready), 1);
        @(negedge clk);

        // R1: nonzero bytes only
        s = {8'h11, 8'h22, 8'hFE};
        run_stream(s);
        drain();

        // R2: lone zero and a run of seven
        s = {8'h05, 8'h00, 8'h06};
        for (int i = 0; i < 7; i++) s.push_back(8'h00);
        s.push_back(8'h80);
        run_stream(s);
        drain();

        // R3: runs of exactly 255, of 256, and of 600
        s = {};
        for (int i = 0; i < 255; i++) s.push_back(8'h00);
        s.push_back(8'h01);
        for (int i = 0; i < 256; i++) s.push_back(8'h00);
        s.push_back(8'h02);
        for (int i = 0; i < 600; i++) s.push_back(8'h00);
        s.push_back(8'h03);
        run_stream(s);
        drain();

        // R4: stream ending on an open run, and a single-zero stream
        s = {8'h44, 8'h00, 8'h00, 8'h00};
        run_stream(s);
        s = {8'h00};
        run_stream(s);
        drain();

        // R6/R9: random back-pressure, streams back to back
        bp_on = 1'b1;
        s = {8'h00, 8'h7A, 8'h00, 8'h00, 8'h31, 8'h32, 8'h00, 8'h9C, 8'h00};
        run_stream(s);
        s = {8'hA5, 8'h00, 8'h5A, 8'h00, 8'h00};
        run_stream(s);
        drain();
        check(exp_q.size() == 0, "R9", "back-to-back streams complete", exp_q.size(), 0);
        bp_on = 1'b0;
        repeat (2) @(negedge clk);

        // R8: reset in the middle of a zero run
        for (int i = 0; i < 3; i++) send_byte(8'h00, 1'b0);
        in_valid = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        exp_q.delete();
        #3;
        check(!out_valid, "R8", "out_valid after mid-run reset", int'(out_valid), 0);
        check(in_ready, "R8", "in_ready after mid-run reset", int'(in_ready), 1);
        @(negedge clk);
        s = {8'h09};
        run_stream(s);
        drain();

        summary();
        $finish;
    end
endmodule